// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block gathers the interrupt sources of one 16550-style serial channel and turns them into a single interrupt line and an interrupt identification value. There are four sources. Line errors, modem-line changes and transmitter-empty events arrive as one-cycle pulses from the datapath and are held until software services them. Receive-data-ready and receive-timeout arrive as levels that the datapath keeps asserted while the condition lasts.

Software enables each source through an enable register. It reads the identification register to learn which enabled source has the highest priority. It then services that source by reading the line or modem status register, by reading the identification value itself, or by loading the transmitter. Lower-priority sources that are still pending are reported on later reads.

Register accesses come in as single-cycle host read and write strobes with a 3-bit register address. The block decodes only the addresses it needs. The interrupt pin can be driven, forced low, or released to high impedance under register and strap control.

Top module: `uart_irq`

## Requirements
- R1: After reset, `isrOut` is 0x01, every enable bit is 0, FIFO mode is off, and the pin is released (`intOe` = 0, `intOut` = 0) while `intSelDrive` = 0 and `contMode` = 0.
- R2: `isrOut[3:0]` names the highest enabled pending source. The ranking, from highest to lowest, is: line error 0x6, receive data 0x4, receive timeout 0xC, transmitter empty 0x2, modem change 0x0. With nothing pending the value is 0x1.
- R3: Reading the identification register (read strobe at address 2) does not clear a pending line-error or modem source. A lower source that stays pending is reported once the higher one is serviced.
- R4: A read at address 5 clears a pending line error. A read at address 6 clears a pending modem change.
- R5: A pending transmitter-empty source clears when an identification read happens while it is the reported source. With FIFO mode off, it also clears on a write to address 0.
- R6: With FIFO mode on, a write to address 0 leaves the transmitter-empty source pending. A `txFillTrig` pulse clears it.
- R7: Receive timeout is reported only while FIFO mode is on.
- R8: A write to address 2 sets FIFO mode from data bit 0. While FIFO mode is on, `isrOut[7:6]` reads 11, and otherwise 00. Bits 5:4 always read 0.
- R9: With FIFO mode on and enable bits 3:0 all 0, `isrOut` reads 0xC1 and no interrupt is signalled, whatever is pending.
- R10: A write to address 1 loads the enables from data bits 3:0. Bit 0 enables receive data and timeout, bit 1 transmitter empty, bit 2 line error, bit 3 modem change.
- R11: A write to address 4 sets the pin enable from data bit 3. With the pin enabled, `intOe` = 1 and `intOut` = 1 exactly when `isrOut[0]` = 0. With the pin disabled, `intSelDrive` = 1 gives `intOe` = 1 with `intOut` = 0, and `intSelDrive` = 0 gives `intOe` = 0.
- R12: With `contMode` = 1, `intOe` = 1 and `intOut` follows the interrupt state regardless of the pin enable.
- R13: If an event pulse arrives in the same cycle as a clearing action for its source, the source remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe, one cycle |
| rdEn | input | 1 | Host read strobe, one cycle |
| regAddr | input | 3 | Register address of the access |
| wrData | input | 8 | Host write data |
| lineEvt | input | 1 | Pulse: a line error was detected |
| rxAvail | input | 1 | Level: received data at or above the trigger |
| rxTimeout | input | 1 | Level: receive character timeout |
| txEmptyEvt | input | 1 | Pulse: transmit holding space became empty |
| txFillTrig | input | 1 | Pulse: TX FIFO filled up to its trigger level |
| modemEvt | input | 1 | Pulse: a modem input changed |
| intSelDrive | input | 1 | Strap: drive low instead of releasing when disabled |
| contMode | input | 1 | Strap: pin always driven |
| isrOut | output | 8 | Identification register value |
| intOut | output | 1 | Interrupt pin value (active high) |
| intOe | output | 1 | Interrupt pin output enable |

## Verification
The bench targets the orderings that a priority encoder gets wrong. It stacks all sources and peels them off one at a time; a swapped rank would report a lower source first. It also reads the identification value while a line error outranks a pending transmitter-empty source. A design that cleared on every identification read would lose the queued source, and one that cleared the transmitter on any read would drop it early. It checks that a write to the transmit address clears the transmitter source only outside FIFO mode, that timeout disappears when FIFO mode is turned off, and that an event arriving on its own clearing cycle survives; a clear-wins flop would lose that event. Every strap and enable combination of the pin is swept, where a wrong decode shows up as a floating or stuck output.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int EN_W   = 4;

  // register addresses used by the controller
  localparam logic [ADDR_W-1:0] A_TXHOLD = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] A_IDENT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODEMC = 3'd4;
  localparam logic [ADDR_W-1:0] A_LINEST = 3'd5;
  localparam logic [ADDR_W-1:0] A_MODEMS = 3'd6;

  // enable bit positions
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  // latched source slots
  localparam int SLOT_LINE  = 0;
  localparam int SLOT_TX    = 1;
  localparam int SLOT_MODEM = 2;
  localparam int N_SLOTS    = 3;

  localparam int PIN_EN_BIT = 3;

  typedef enum logic [3:0] {
    ID_MODEM = 4'h0,
    ID_NONE  = 4'h1,
    ID_TXE   = 4'h2,
    ID_RXD   = 4'h4,
    ID_LINE  = 4'h6,
    ID_RXTO  = 4'hC
  } idCodeE;

  typedef struct packed {
    logic txHoldWr;
    logic identRd;
    logic lineStRd;
    logic modemStRd;
  } hostStrobeT;
endpackage

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int AddrW = ADDR_W,
  parameter int DataW = DATA_W,
  parameter int EnW   = EN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [AddrW-1:0] regAddr,
  input  logic [DataW-1:0] wrData,
  output hostStrobeT       strb,
  output logic [EnW-1:0]   enBits,
  output logic             fifoOn,
  output logic             pinEnable
);
  logic enWr, fifoWr, modemCtlWr;

  always_comb begin
    strb.txHoldWr  = wrEn && (regAddr == A_TXHOLD);
    strb.identRd   = rdEn && (regAddr == A_IDENT);
    strb.lineStRd  = rdEn && (regAddr == A_LINEST);
    strb.modemStRd = rdEn && (regAddr == A_MODEMS);
    enWr           = wrEn && (regAddr == A_ENABLE);
    fifoWr         = wrEn && (regAddr == A_IDENT);
    modemCtlWr     = wrEn && (regAddr == A_MODEMC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBits    <= '0;
      fifoOn    <= 1'b0;
      pinEnable <= 1'b0;
    end else begin
      if (enWr)       enBits    <= wrData[EnW-1:0];
      if (fifoWr)     fifoOn    <= wrData[0];
      if (modemCtlWr) pinEnable <= wrData[PIN_EN_BIT];
    end
  end

  // R10
  enable_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    enWr |=> enBits == $past(wrData[EnW-1:0]));
  // R8
  fifo_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |=> fifoOn == $past(wrData[0]));
endmodule

// File: rtl/uart_irq_core.sv
`timescale 1ns/1ps
module uart_irq_core
  import uart_irq_pkg::*;
#(
  parameter int EnW   = EN_W,
  parameter int DataW = DATA_W,
  parameter int Slots = N_SLOTS
) (
  input  logic             clk,
  input  logic             rstN,
  input  hostStrobeT       strb,
  input  logic [EnW-1:0]   enBits,
  input  logic             fifoOn,
  input  logic             lineEvt,
  input  logic             rxAvail,
  input  logic             rxTimeout,
  input  logic             txEmptyEvt,
  input  logic             txFillTrig,
  input  logic             modemEvt,
  output logic [DataW-1:0] isrOut,
  output logic             irqActive
);
  logic [Slots-1:0] pendQ, setVec, clrVec;
  idCodeE curId;

  always_comb begin
    setVec             = '0;
    setVec[SLOT_LINE]  = lineEvt;
    setVec[SLOT_TX]    = txEmptyEvt;
    setVec[SLOT_MODEM] = modemEvt;
    clrVec             = '0;
    clrVec[SLOT_LINE]  = strb.lineStRd;
    clrVec[SLOT_MODEM] = strb.modemStRd;
    clrVec[SLOT_TX]    = (strb.identRd && curId == ID_TXE)
                       || (strb.txHoldWr && !fifoOn)
                       || (txFillTrig && fifoOn);
  end

  // one sticky flag per latched source; a new event outranks its clear
  for (genvar s = 0; s < Slots; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          pendQ[s] <= 1'b0;
      else if (setVec[s]) pendQ[s] <= 1'b1;
      else if (clrVec[s]) pendQ[s] <= 1'b0;
    end
  end

  // priority: later assignments override earlier ones
  always_comb begin
    curId = ID_NONE;
    if (enBits[EN_MODEM] && pendQ[SLOT_MODEM])  curId = ID_MODEM;
    if (enBits[EN_TX] && pendQ[SLOT_TX])        curId = ID_TXE;
    if (enBits[EN_RX] && rxTimeout && fifoOn)   curId = ID_RXTO;
    if (enBits[EN_RX] && rxAvail)               curId = ID_RXD;
    if (enBits[EN_LINE] && pendQ[SLOT_LINE])    curId = ID_LINE;
  end

  always_comb begin
    isrOut      = '0;
    isrOut[3:0] = curId;
    isrOut[DataW-1] = fifoOn;
    isrOut[DataW-2] = fifoOn;
    irqActive   = (curId != ID_NONE);
  end

  // R4
  line_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineStRd && !lineEvt |=> !pendQ[SLOT_LINE]);
  // R3
  ident_keeps_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.identRd && pendQ[SLOT_LINE] && !strb.lineStRd |=> pendQ[SLOT_LINE]);
  // R13
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyEvt |=> pendQ[SLOT_TX]);
  // R6
  fifo_hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoOn && strb.txHoldWr && pendQ[SLOT_TX] && !strb.identRd && !txFillTrig
    |=> pendQ[SLOT_TX]);
  // R9
  polled_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoOn && enBits[3:0] == 4'h0 |-> isrOut == 8'hC1 && !irqActive);
  // R7
  timeout_fifo_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fifoOn |-> isrOut[3:0] != 4'hC);
endmodule

// File: rtl/uart_irq_pin.sv
`timescale 1ns/1ps
module uart_irq_pin (
  input  logic irqActive,
  input  logic pinEnable,
  input  logic intSelDrive,
  input  logic contMode,
  output logic intOut,
  output logic intOe
);
  always_comb begin
    if (contMode || pinEnable) begin
      intOe  = 1'b1;
      intOut = irqActive;
    end else begin
      intOe  = intSelDrive;
      intOut = 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq.sv
`timescale 1ns/1ps
module uart_irq
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  wrData,
  input  logic        lineEvt,
  input  logic        rxAvail,
  input  logic        rxTimeout,
  input  logic        txEmptyEvt,
  input  logic        txFillTrig,
  input  logic        modemEvt,
  input  logic        intSelDrive,
  input  logic        contMode,
  output logic [7:0]  isrOut,
  output logic        intOut,
  output logic        intOe
);
  hostStrobeT     strb;
  logic [EN_W-1:0] enBits;
  logic           fifoOn, pinEnable, irqActive;

  uart_irq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .strb(strb), .enBits(enBits), .fifoOn(fifoOn),
    .pinEnable(pinEnable)
  );

  uart_irq_core i_core (
    .clk(clk), .rstN(rstN), .strb(strb), .enBits(enBits), .fifoOn(fifoOn),
    .lineEvt(lineEvt), .rxAvail(rxAvail), .rxTimeout(rxTimeout),
    .txEmptyEvt(txEmptyEvt), .txFillTrig(txFillTrig), .modemEvt(modemEvt),
    .isrOut(isrOut), .irqActive(irqActive)
  );

  uart_irq_pin i_pin (
    .irqActive(irqActive), .pinEnable(pinEnable), .intSelDrive(intSelDrive),
    .contMode(contMode), .intOut(intOut), .intOe(intOe)
  );

  // R12
  cont_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    contMode |-> intOe && (intOut == !isrOut[0]));
  // R11
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !contMode && !pinEnable && !intSelDrive |-> !intOe && !intOut);
endmodule

// File: tb/test_uart_irq.sv
`timescale 1ns/1ps
module test_uart_irq;
  logic clk = 0, rstN = 0;
  logic wrEn = 0, rdEn = 0;
  logic [2:0] regAddr = 0;
  logic [7:0] wrData = 0;
  logic lineEvt = 0, rxAvail = 0, rxTimeout = 0, txEmptyEvt = 0;
  logic txFillTrig = 0, modemEvt = 0, intSelDrive = 0, contMode = 0;
  logic [7:0] isrOut;
  logic intOut, intOe;

  int nChecks = 0, nFails = 0;
  string curReq = "R1";
  bit done = 0;

  uart_irq i_uart_irq (.*);

  always #2.5 clk = ~clk;

  // behavioural reference state
  bit [3:0] mEn;
  bit mFifo, mPin, mLine, mTx, mModem;

  function automatic bit [3:0] refId();
    if (mEn[2] && mLine)           return 4'h6;
    if (mEn[0] && rxAvail)         return 4'h4;
    if (mEn[0] && rxTimeout && mFifo) return 4'hC;
    if (mEn[1] && mTx)             return 4'h2;
    if (mEn[3] && mModem)          return 4'h0;
    return 4'h1;
  endfunction

  function automatic bit [7:0] refIsr();
    return {mFifo, mFifo, 2'b00, refId()};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mFifo = 0; mPin = 0; mLine = 0; mTx = 0; mModem = 0;
    end else begin
      bit identRd, txClr;
      identRd = rdEn && regAddr == 3'd2;
      txClr = (identRd && refId() == 4'h2) || (wrEn && regAddr == 3'd0 && !mFifo)
              || (txFillTrig && mFifo);
      if (lineEvt) mLine = 1; else if (rdEn && regAddr == 3'd5) mLine = 0;
      if (modemEvt) mModem = 1; else if (rdEn && regAddr == 3'd6) mModem = 0;
      if (txEmptyEvt) mTx = 1; else if (txClr) mTx = 0;
      if (wrEn && regAddr == 3'd1) mEn = wrData[3:0];
      if (wrEn && regAddr == 3'd2) mFifo = wrData[0];
      if (wrEn && regAddr == 3'd4) mPin = wrData[3];
    end
    #1;
    if (rstN && !done) begin
      bit expOe, expOut, act;
      act = refId() != 4'h1;
      if (contMode || mPin) begin expOe = 1; expOut = act; end
      else begin expOe = intSelDrive; expOut = 0; end
      chk(isrOut == refIsr(), curReq, isrOut, refIsr());
      chk(intOe == expOe, curReq, intOe, expOe);
      chk(intOut == expOut, curReq, intOut, expOut);
    end
  end

  // one bus cycle: access plus event mask {modem, fill, txEmpty, line}
  task automatic cyc(bit w, bit r, bit [2:0] a, bit [7:0] d, bit [3:0] ev);
    @(negedge clk);
    wrEn = w; rdEn = r; regAddr = a; wrData = d;
    lineEvt = ev[0]; txEmptyEvt = ev[1]; txFillTrig = ev[2]; modemEvt = ev[3];
    @(negedge clk);
    wrEn = 0; rdEn = 0; lineEvt = 0; txEmptyEvt = 0; txFillTrig = 0; modemEvt = 0;
  endtask

  task automatic wr(bit [2:0] a, bit [7:0] d); cyc(1, 0, a, d, 4'h0); endtask
  task automatic rd(bit [2:0] a);              cyc(0, 1, a, 8'h0, 4'h0); endtask
  task automatic ev(bit [3:0] m);              cyc(0, 0, 3'd0, 8'h0, m); endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    chk(isrOut == 8'h01, "R1", isrOut, 8'h01);
    chk(intOe == 0 && intOut == 0, "R1", {intOe, intOut}, 0);
    rstN = 1;
    @(negedge clk);

    curReq = "R10"; wr(3'd1, 8'h0F);
    curReq = "R11"; wr(3'd4, 8'h08);
    curReq = "R2";
    rxAvail = 1;
    ev(4'b1011);
    chk(isrOut == 8'h06, "R2", isrOut, 8'h06);
    curReq = "R4"; rd(3'd5);
    chk(isrOut == 8'h04, "R4", isrOut, 8'h04);
    curReq = "R2"; rxAvail = 0; @(negedge clk);
    chk(isrOut == 8'h02, "R2", isrOut, 8'h02);
    curReq = "R5"; rd(3'd2);
    chk(isrOut == 8'h00, "R5", isrOut, 8'h00);
    curReq = "R4"; rd(3'd6);
    chk(isrOut == 8'h01 && intOut == 0, "R4", isrOut, 8'h01);

    curReq = "R3"; ev(4'b0011); rd(3'd2);
    chk(isrOut == 8'h06, "R3", isrOut, 8'h06);
    rd(3'd5);
    chk(isrOut == 8'h02, "R3", isrOut, 8'h02);
    curReq = "R5"; wr(3'd0, 8'h55);
    chk(isrOut == 8'h01, "R5", isrOut, 8'h01);
    curReq = "R10"; ev(4'b0010); wr(3'd1, 8'h04);
    chk(isrOut == 8'h01, "R10", isrOut, 8'h01);
    wr(3'd1, 8'h0F); rd(3'd2);

    curReq = "R8"; wr(3'd2, 8'h01);
    chk(isrOut == 8'hC1, "R8", isrOut, 8'hC1);
    curReq = "R7"; rxTimeout = 1; @(negedge clk);
    chk(isrOut == 8'hCC, "R7", isrOut, 8'hCC);
    wr(3'd2, 8'h00);
    chk(isrOut == 8'h01, "R7", isrOut, 8'h01);
    rxTimeout = 0; wr(3'd2, 8'h01);

    curReq = "R6"; ev(4'b0010); wr(3'd0, 8'hAA);
    chk(isrOut == 8'hC2, "R6", isrOut, 8'hC2);
    ev(4'b0100);
    chk(isrOut == 8'hC1, "R6", isrOut, 8'hC1);
    ev(4'b0010); rd(3'd2);
    chk(isrOut == 8'hC1, "R6", isrOut, 8'hC1);

    curReq = "R9"; ev(4'b1011); rxAvail = 1; wr(3'd1, 8'h00);
    chk(isrOut == 8'hC1 && intOut == 0, "R9", isrOut, 8'hC1);
    rxAvail = 0; wr(3'd1, 8'h0F);

    curReq = "R11"; wr(3'd4, 8'h00);
    chk(intOe == 0, "R11", intOe, 0);
    intSelDrive = 1; @(negedge clk);
    chk(intOe == 1 && intOut == 0, "R11", {intOe, intOut}, 2);
    curReq = "R12"; contMode = 1; @(negedge clk);
    chk(intOe == 1 && intOut == 1, "R12", {intOe, intOut}, 3);
    intSelDrive = 0; @(negedge clk);

    curReq = "R13"; rd(3'd5); rd(3'd6); wr(3'd2, 8'h00);
    cyc(1, 0, 3'd0, 8'h11, 4'b0010);
    chk(isrOut == 8'h02, "R13", isrOut, 8'h02);
    cyc(0, 1, 3'd5, 8'h00, 4'b0001);
    chk(isrOut == 8'h06, "R13", isrOut, 8'h06);
    contMode = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule